// File: doc/BRIEF.md
# Indexed Host Register Port with DMA Handshake

This block is the host-facing side of an audio codec core. A byte-wide asynchronous host bus (separate read and write strobes, chip select, a 2-bit address) is brought into the core clock domain. Two address locations give index/data access to a bank of indirect registers. A third location is a status register. The fourth location moves sample bytes: writes go to a playback FIFO and reads come from a capture FIFO. Each FIFO also has its own request/acknowledge pair for DMA transfers, and those transfers do not use chip select or the address. The converter side of the core fills the capture FIFO and drains the playback FIFO through simple push/pop ports.

The block drives enable and direction controls for an external data-bus transceiver straight from the bus pins. It also gathers three interrupt sources (playback count, capture count, timer) into pending bits and drives an interrupt pin that is gated by an enable bit. A mode bit in the miscellaneous register widens the indirect space from 16 to 32 registers.

Top module: `hport`

## Requirements
- R1: A write to address 0 with chip select low loads the 5-bit index. A read of address 0 returns that index in bits 4:0, with bits 7:5 reading 0.
- R2: Address 1 reads and writes the indirect register chosen by the index. While the mode bit is clear, index bit 4 is ignored, so index 19 reaches the same register as index 3.
- R3: The mode bit is bit 6 of indirect register 12. While it is set, indexes 16 to 31 are separate registers. Clearing it restores the 16-register view, and the contents are kept.
- R4: With chip select high, a control or PIO write is ignored, and the transceiver enable stays high unless an acknowledge is low.
- R5: DMA transfers ignore chip select and the address. A write strobe while the playback acknowledge is low pushes the data byte into the playback FIFO. A read strobe while the capture acknowledge is low returns the capture FIFO head and pops it.
- R6: Address 3 with chip select low is the PIO data port. A write pushes into the playback FIFO and a read pops from the capture FIFO.
- R7: The capture request is high exactly while the capture FIFO is not empty. The playback request is high exactly while the playback FIFO (16 bytes) is not full.
- R8: The transceiver enable (active low) is low while a strobe is low and chip select or either acknowledge is low. The direction output is low only while the read strobe is low with the same qualifier, and it is high otherwise.
- R9: The FIFOs keep byte order. A push into a full FIFO or a pop from an empty FIFO is dropped and flagged in status bits 4 to 7: playback overflow, playback underflow, capture overflow, capture underflow. Writing the status register clears these flags.
- R10: The event inputs set pending bits. These show in status bits 1 to 3 (playback, capture, timer) and in extended indirect register 24 bits 4 to 6 (same order). Status bit 0 and the interrupt pin are high when the enable bit (register 10 bit 1) is set and any bit is pending.
- R11: Any write to the status register clears all pending bits. Writing register 24 clears each pending bit written as 0 and keeps each bit written as 1.
- R12: An event that arrives in the same cycle as a clear leaves its pending bit set.
- R13: An access takes effect on the rising edge of its strobe. While a read strobe is held low, the capture FIFO is not popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Direct register address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| cap_ack_ni | input | 1 | Capture DMA acknowledge, active low |
| play_ack_ni | input | 1 | Playback DMA acknowledge, active low |
| cap_req_o | output | 1 | Capture DMA request |
| play_req_o | output | 1 | Playback DMA request |
| xcvr_en_no | output | 1 | External transceiver enable, active low |
| xcvr_dir_o | output | 1 | Transceiver direction, high = host to block |
| irq_o | output | 1 | Interrupt pin |
| cap_push_i | input | 1 | Core pushes a capture byte |
| cap_din_i | input | 8 | Capture byte from core |
| play_pop_i | input | 1 | Core pops a playback byte |
| play_dout_o | output | 8 | Playback FIFO head |
| play_evt_i | input | 1 | Playback count event |
| cap_evt_i | input | 1 | Capture count event |
| timer_evt_i | input | 1 | Timer event |

## Verification
An event pulse and a host clear of the pending bits can land on the same core clock edge. A plain status write causes the clear, and so does writing 0 into the event register. The bench counts the two synchronizer stages and the edge detector after the write strobe is released, so it can raise the timer event exactly on the edge where the clear is applied. It then reads the status back. The timer bit must still be set and the interrupt must stay asserted, while the playback bit that was pending beforehand has been cleared. This shows that the clear took effect and that the new event won.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int DW        = 8;
  localparam int IDX_W     = 5;
  localparam int MISC_IDX  = 12;
  localparam int MODE_BIT  = 6;
  localparam int IRQ_IDX   = 10;
  localparam int IEN_BIT   = 1;
  localparam int EVT_IDX   = 24;
  localparam int EVT_LSB   = 4;

  typedef enum logic [1:0] {
    A_INDEX  = 2'd0,
    A_IDATA  = 2'd1,
    A_STATUS = 2'd2,
    A_PIO    = 2'd3
  } port_addr_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign ovf_o   = push_i && full_o;
  assign unf_o   = pop_i && empty_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic          reg_wr_i,
  input  logic          stat_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [2:0]    evt_i,    // {timer, cap, play}
  input  logic [3:0]    err_i,    // {cap_unf, cap_ovf, play_unf, play_ovf}
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] status_o,
  output logic          ien_o,
  output logic [2:0]    pend_o,
  output logic          irq_o
);
  localparam int NREG = 2 ** IW;

  logic [DW-1:0] bank_q [NREG];
  logic [IW-1:0] idx_q, eff_idx;
  logic [2:0]    pend_q, clr;
  logic [3:0]    err_q;
  logic          mode, evt_sel, int_st;

  assign mode    = bank_q[MISC_IDX][MODE_BIT];
  assign ien_o   = bank_q[IRQ_IDX][IEN_BIT];
  assign eff_idx = mode ? idx_q : {1'b0, idx_q[IW-2:0]};
  assign evt_sel = (eff_idx == IW'(EVT_IDX));

  always_comb begin
    clr = 3'b000;
    if (stat_wr_i)                clr = 3'b111;
    else if (reg_wr_i && evt_sel) clr = ~wdata_i[EVT_LSB +: 3];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pend_q <= '0;
      err_q  <= '0;
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else begin
      if (idx_wr_i) idx_q <= wdata_i[IW-1:0];
      if (reg_wr_i && !evt_sel) bank_q[eff_idx] <= wdata_i;
      pend_q <= (pend_q & ~clr) | evt_i;
      err_q  <= stat_wr_i ? err_i : (err_q | err_i);
    end
  end

  assign int_st   = ien_o && (|pend_q);
  assign irq_o    = int_st;
  assign pend_o   = pend_q;
  assign idx_o    = idx_q;
  assign status_o = {err_q, pend_q, int_st};
  assign rdata_o  = evt_sel ? DW'({pend_q, 4'b0000}) : bank_q[eff_idx];
endmodule

// File: rtl/hport.sv
module hport
  import hp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic          cap_ack_ni,
  input  logic          play_ack_ni,
  output logic          cap_req_o,
  output logic          play_req_o,
  output logic          xcvr_en_no,
  output logic          xcvr_dir_o,
  output logic          irq_o,
  input  logic          cap_push_i,
  input  logic [DW-1:0] cap_din_i,
  input  logic          play_pop_i,
  output logic [DW-1:0] play_dout_o,
  input  logic          play_evt_i,
  input  logic          cap_evt_i,
  input  logic          timer_evt_i
);
  localparam int CTL_W = 5;
  localparam int DAT_W = 2 + DW;

  // transceiver controls straight from the pins
  logic qual;
  assign qual       = !cs_ni || !cap_ack_ni || !play_ack_ni;
  assign xcvr_en_no = !((!rd_ni || !wr_ni) && qual);
  assign xcvr_dir_o = !(!rd_ni && qual);

  logic [CTL_W-1:0] ctl_s;
  logic [DAT_W-1:0] dat_s;
  logic rd_s, wr_s, cs_s, cack_s, pack_s;

  hp_sync #(.W(CTL_W), .RST_VAL('1)) u_sync_ctl (
    .clk_i, .rst_ni,
    .d_i({rd_ni, wr_ni, cs_ni, cap_ack_ni, play_ack_ni}),
    .q_o(ctl_s)
  );
  hp_sync #(.W(DAT_W), .RST_VAL('0)) u_sync_dat (
    .clk_i, .rst_ni,
    .d_i({addr_i, data_i}),
    .q_o(dat_s)
  );
  assign {rd_s, wr_s, cs_s, cack_s, pack_s} = ctl_s;

  logic          rd_d, wr_d, cs_h, cack_h, pack_h;
  port_addr_e    addr_h;
  logic [DW-1:0] data_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_d   <= 1'b1;
      wr_d   <= 1'b1;
      cs_h   <= 1'b1;
      cack_h <= 1'b1;
      pack_h <= 1'b1;
      addr_h <= A_INDEX;
      data_h <= '0;
    end else begin
      rd_d <= rd_s;
      wr_d <= wr_s;
      if (!rd_s || !wr_s) begin
        cs_h   <= cs_s;
        cack_h <= cack_s;
        pack_h <= pack_s;
        addr_h <= port_addr_e'(dat_s[DAT_W-1 -: 2]);
        data_h <= dat_s[DW-1:0];
      end
    end
  end

  logic rd_rise, wr_rise, ctl_wr;
  assign rd_rise = rd_s && !rd_d;
  assign wr_rise = wr_s && !wr_d;
  assign ctl_wr  = wr_rise && pack_h && !cs_h;

  logic play_push, cap_pop, idx_wr, reg_wr, stat_wr;
  assign play_push = wr_rise && (!pack_h || (!cs_h && addr_h == A_PIO));
  assign cap_pop   = rd_rise && (!cack_h || (!cs_h && addr_h == A_PIO));
  assign idx_wr    = ctl_wr && (addr_h == A_INDEX);
  assign reg_wr    = ctl_wr && (addr_h == A_IDATA);
  assign stat_wr   = ctl_wr && (addr_h == A_STATUS);

  logic          play_full, play_empty, play_ovf, play_unf;
  logic          cap_full, cap_empty, cap_ovf, cap_unf;
  logic [DW-1:0] cap_head;

  hp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_play (
    .clk_i, .rst_ni,
    .push_i(play_push), .din_i(data_h),
    .pop_i(play_pop_i), .dout_o(play_dout_o),
    .full_o(play_full), .empty_o(play_empty),
    .ovf_o(play_ovf), .unf_o(play_unf)
  );
  hp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_cap (
    .clk_i, .rst_ni,
    .push_i(cap_push_i), .din_i(cap_din_i),
    .pop_i(cap_pop), .dout_o(cap_head),
    .full_o(cap_full), .empty_o(cap_empty),
    .ovf_o(cap_ovf), .unf_o(cap_unf)
  );

  assign cap_req_o  = !cap_empty;
  assign play_req_o = !play_full;

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    reg_rdata, status;
  logic             ien;
  logic [2:0]       pend;

  hp_regs u_regs (
    .clk_i, .rst_ni,
    .idx_wr_i(idx_wr), .reg_wr_i(reg_wr), .stat_wr_i(stat_wr),
    .wdata_i(data_h),
    .evt_i({timer_evt_i, cap_evt_i, play_evt_i}),
    .err_i({cap_unf, cap_ovf, play_unf, play_ovf}),
    .idx_o(idx), .rdata_o(reg_rdata), .status_o(status),
    .ien_o(ien), .pend_o(pend), .irq_o(irq_o)
  );

  always_comb begin
    if (!cack_h) data_o = cap_head;
    else begin
      unique case (addr_h)
        A_INDEX:  data_o = DW'(idx);
        A_IDATA:  data_o = reg_rdata;
        A_STATUS: data_o = status;
        default:  data_o = cap_head;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{cap_full, play_empty};
endmodule

// File: rtl/hport_chk.sv
module hport_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_ni,
  input logic       wr_ni,
  input logic       cap_req_o,
  input logic       play_req_o,
  input logic       cap_push_i,
  input logic       play_pop_i,
  input logic       xcvr_en_no,
  input logic       xcvr_dir_o,
  input logic       irq_o,
  input logic       ien,
  input logic       timer_evt_i,
  input logic [2:0] pend
);
  // R7
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_req_o && !cap_push_i) |=> !cap_req_o);
  // R7
  play_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!play_req_o && !play_pop_i) |=> !play_req_o);
  // R8
  dir_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> xcvr_dir_o);
  // R8
  en_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && wr_ni) |-> xcvr_en_no);
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien |-> !irq_o);
  // R12
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_evt_i |=> pend[2]);
endmodule

bind hport hport_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .cap_req_o(cap_req_o), .play_req_o(play_req_o),
  .cap_push_i(cap_push_i), .play_pop_i(play_pop_i),
  .xcvr_en_no(xcvr_en_no), .xcvr_dir_o(xcvr_dir_o),
  .irq_o(irq_o), .ien(ien), .timer_evt_i(timer_evt_i), .pend(pend)
);

// File: tb/hport_tb.sv
module hport_tb;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, cack_n = 1, pack_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, dout, cap_din = 0, play_dout;
  logic cap_req, play_req, en_n, dir, irq;
  logic cap_push = 0, play_pop = 0, pevt = 0, cevt = 0, tevt = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic s_en, s_dir;

  always #2 clk = ~clk;

  hport u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout),
    .cap_ack_ni(cack_n), .play_ack_ni(pack_n),
    .cap_req_o(cap_req), .play_req_o(play_req),
    .xcvr_en_no(en_n), .xcvr_dir_o(dir), .irq_o(irq),
    .cap_push_i(cap_push), .cap_din_i(cap_din),
    .play_pop_i(play_pop), .play_dout_o(play_dout),
    .play_evt_i(pevt), .cap_evt_i(cevt), .timer_evt_i(tevt)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic c, logic [1:0] a, logic [7:0] d, logic pk = 1);
    @(negedge clk);
    cs_n = c; addr = a; din = d; pack_n = pk;
    repeat (2) @(negedge clk);
    wr_n = 0;
    repeat (5) @(negedge clk);
    s_en = en_n; s_dir = dir;
    wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1; pack_n = 1;
  endtask

  task automatic bus_rd(logic c, logic [1:0] a, output logic [7:0] d, input logic ck = 1);
    @(negedge clk);
    cs_n = c; addr = a; cack_n = ck;
    repeat (2) @(negedge clk);
    rd_n = 0;
    repeat (6) @(negedge clk);
    d = dout; s_en = en_n; s_dir = dir;
    rd_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1; cack_n = 1;
  endtask

  task automatic ireg_wr(logic [7:0] i, logic [7:0] d);
    bus_wr(0, 2'd0, i);
    bus_wr(0, 2'd1, d);
  endtask

  task automatic ireg_rd(logic [7:0] i, output logic [7:0] d);
    bus_wr(0, 2'd0, i);
    bus_rd(0, 2'd1, d);
  endtask

  task automatic core_push(logic [7:0] d);
    @(negedge clk); cap_push = 1; cap_din = d;
    @(negedge clk); cap_push = 0;
  endtask

  task automatic core_pop(output logic [7:0] d);
    @(negedge clk); d = play_dout; play_pop = 1;
    @(negedge clk); play_pop = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R7 reset cap_req", {7'b0, cap_req}, 8'h00);
    chk("R7 reset play_req", {7'b0, play_req}, 8'h01);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    chk("R8 reset en/dir", {6'b0, en_n, dir}, 8'h03);
    bus_rd(0, 2'd2, v);
    chk("R9 reset status", v, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    bus_wr(0, 2'd0, 8'h05);
    chk("R8 write en/dir", {6'b0, s_en, s_dir}, 8'h01);
    bus_rd(0, 2'd0, v);
    chk("R1 index readback", v, 8'h05);
    chk("R8 read en/dir", {6'b0, s_en, s_dir}, 8'h00);
    bus_wr(0, 2'd0, 8'hFF);
    bus_rd(0, 2'd0, v);
    chk("R1 index width", v, 8'h1F);
  endtask

  task automatic t_indirect();
    logic [7:0] v;
    ireg_wr(8'd3, 8'hA5);
    ireg_wr(8'd4, 8'h5A);
    ireg_rd(8'd3, v);
    chk("R2 indirect 3", v, 8'hA5);
    ireg_rd(8'd4, v);
    chk("R2 indirect 4", v, 8'h5A);
    ireg_wr(8'd19, 8'h77);
    ireg_rd(8'd3, v);
    chk("R2 alias 19->3", v, 8'h77);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    ireg_wr(8'd12, 8'h40);
    ireg_wr(8'd19, 8'h11);
    ireg_rd(8'd3, v);
    chk("R3 reg 3 kept", v, 8'h77);
    ireg_rd(8'd19, v);
    chk("R3 reg 19 separate", v, 8'h11);
    ireg_wr(8'd12, 8'h00);
    ireg_rd(8'd19, v);
    chk("R3 base view restored", v, 8'h77);
  endtask

  task automatic t_cs();
    logic [7:0] v;
    bus_wr(0, 2'd0, 8'h02);
    bus_wr(1, 2'd0, 8'h09);
    chk("R4 en idle cs high", {7'b0, s_en}, 8'h01);
    bus_rd(0, 2'd0, v);
    chk("R4 index unchanged", v, 8'h02);
    bus_wr(1, 2'd3, 8'h44);
    chk("R4 no PIO push", {7'b0, play_req}, 8'h01);
  endtask

  task automatic t_play_fifo();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) bus_wr(1, 2'd2, 8'h30 + 8'(i), 0);
    chk("R5 DMA en", {7'b0, s_en}, 8'h00);
    chk("R7 play_req full", {7'b0, play_req}, 8'h00);
    bus_wr(1, 2'd0, 8'hEE, 0);
    bus_rd(0, 2'd2, v);
    chk("R9 play ovf flag", v, 8'h10);
    for (int i = 0; i < 16; i++) begin
      core_pop(v);
      chk("R9 play order", v, 8'h30 + 8'(i));
    end
    @(negedge clk);
    chk("R7 play_req after drain", {7'b0, play_req}, 8'h01);
    core_pop(v);
    bus_rd(0, 2'd2, v);
    chk("R9 play unf flag", v, 8'h30);
    bus_wr(0, 2'd2, 8'h00);
    bus_rd(0, 2'd2, v);
    chk("R9 flags cleared", v, 8'h00);
    bus_wr(0, 2'd3, 8'h9C);
    core_pop(v);
    chk("R6 PIO write to playback", v, 8'h9C);
  endtask

  task automatic t_cap_fifo();
    logic [7:0] v;
    core_push(8'hC1); core_push(8'hC2); core_push(8'hC3);
    @(negedge clk);
    chk("R7 cap_req nonempty", {7'b0, cap_req}, 8'h01);
    bus_rd(1, 2'd0, v, 0);
    chk("R5 DMA read 1", v, 8'hC1);
    chk("R8 DMA read dir", {6'b0, s_en, s_dir}, 8'h00);
    bus_rd(1, 2'd1, v, 0);
    chk("R5 DMA read 2", v, 8'hC2);
    bus_rd(0, 2'd3, v);
    chk("R6 PIO read 3", v, 8'hC3);
    chk("R7 cap_req empty", {7'b0, cap_req}, 8'h00);
    bus_rd(0, 2'd3, v);
    bus_rd(0, 2'd2, v);
    chk("R9 cap unf flag", v, 8'h80);
    bus_wr(0, 2'd2, 8'h00);
    core_push(8'hD7);
    @(negedge clk);
    cack_n = 0;
    repeat (2) @(negedge clk);
    rd_n = 0;
    repeat (8) @(negedge clk);
    chk("R13 no pop while strobe low", {7'b0, cap_req}, 8'h01);
    chk("R13 head on bus", dout, 8'hD7);
    rd_n = 1;
    repeat (4) @(negedge clk);
    cack_n = 1;
    chk("R13 pop on release", {7'b0, cap_req}, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk); tevt = 1; @(negedge clk); tevt = 0;
    @(negedge clk);
    chk("R10 irq gated off", {7'b0, irq}, 8'h00);
    bus_rd(0, 2'd2, v);
    chk("R10 pending w/o enable", v, 8'h08);
    ireg_wr(8'd10, 8'h02);
    @(negedge clk);
    chk("R10 irq enabled", {7'b0, irq}, 8'h01);
    ireg_wr(8'd12, 8'h40);
    ireg_wr(8'd24, 8'h00);
    @(negedge clk);
    chk("R11 event reg clear", {7'b0, irq}, 8'h00);
    @(negedge clk); pevt = 1; cevt = 1; tevt = 1;
    @(negedge clk); pevt = 0; cevt = 0; tevt = 0;
    ireg_rd(8'd24, v);
    chk("R10 event reg bits", v, 8'h70);
    bus_wr(0, 2'd1, 8'h20);
    bus_rd(0, 2'd1, v);
    chk("R11 selective clear", v, 8'h20);
    bus_wr(0, 2'd2, 8'hFF);
    @(negedge clk);
    chk("R11 status write clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk); pevt = 1; @(negedge clk); pevt = 0;
    @(negedge clk);
    cs_n = 0; addr = 2'd2; din = 8'h00;
    repeat (2) @(negedge clk);
    wr_n = 0;
    repeat (5) @(negedge clk);
    wr_n = 1;
    @(posedge clk);
    @(posedge clk);
    #1 tevt = 1;
    @(posedge clk);
    #1 tevt = 0;
    repeat (3) @(negedge clk);
    cs_n = 1;
    chk("R12 irq kept", {7'b0, irq}, 8'h01);
    bus_rd(0, 2'd2, v);
    chk("R12 timer survives clear", v, 8'h09);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_index();
    t_indirect();
    t_mode();
    t_cs();
    t_play_fifo();
    t_cap_fifo();
    t_irq();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule